// File: doc/BRIEF.md
# Paged EEPROM Device Emulator

This block is a synthesizable stand-in for a byte-wide parallel EEPROM with page programming. It is placed on the far side of a memory controller under test. It watches the chip-select, write-enable and output-enable pins on a fast system clock. Byte loads are gathered into a page buffer with one entry per page offset. Once the load window has been quiet for long enough, the block enters a busy period. During that period it copies the loaded entries into its array and answers reads with end-of-write status in place of stored data.

The array holds `2**ADDR_W` bytes. `ADDR_W = 15` gives the full 32768-byte device; the default is smaller so the block elaborates cheaply. The low `OFS_W` address bits (6, giving a 64-byte page) select the page offset, and the upper bits select the page. Both timing windows are counted in system clock cycles. At 50 MHz, a 150 us load window is 7500 cycles, and a busy time of 5 ms to 10 ms is 250000 to 500000 cycles. `BUSY_CYC` must exceed the page size.

Top module: `eeprom_emu`

## Requirements
- R1: Outside a busy period, a read (ce_n=0, oe_n=0, we_n=1) returns on `dout` the byte last committed at `addr`.
- R2: A load is taken in the first clock cycle in which ce_n and we_n are both seen low. It writes `din` into the page-buffer entry selected by `addr[OFS_W-1:0]`, and that byte reaches the array at `addr` after the busy period.
- R3: The page of a burst is fixed by its first load from `addr[ADDR_W-1:OFS_W]`. A later load in the same burst that carries a different page is dropped and programs nothing.
- R4: The busy period starts once LOAD_TMO cycles pass with no accepted load. A load that lands in the cycle where the window would expire extends the window. Before expiry, reads still return true data.
- R5: The busy period lasts BUSY_CYC cycles. Loads that arrive during it are ignored and do not change the array.
- R6: During a busy period, `dout[6]` inverts at every new read strobe. The first read of each busy period returns 1.
- R7: During a busy period, a read returns `dout[7]` as the complement of bit 7 of the last accepted byte, with `dout[5:0]` = 0.
- R8: A write strobe made while oe_n is low is ignored.
- R9: Only the page entries loaded in a burst are programmed. The other bytes of that page keep their contents.
- R10: `dout_en` is 1 only while ce_n=0, oe_n=0 and we_n=1. Otherwise `dout_en` is 0 and `dout` is 0.
- R11: After reset, no load is pending, the block is not busy and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the device pins |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address (low OFS_W bits give the page offset) |
| din | input | 8 | Data written by a load |
| dout | output | 8 | Read data or busy status |
| dout_en | output | 1 | High when the model would drive the data pins |

## Verification
The clash that matters is a new byte load arriving in the exact cycle that the quiet-window counter reaches its limit: the load must win and the burst must grow. The bench places a second load exactly LOAD_TMO cycles after the first, and another pair exactly one cycle further apart. The first pair must both be programmed. In the second pair, the later byte must be dropped because it falls into the busy period. Both outcomes are judged by reading the array back after the busy period, so a one-cycle slip in the window comparison shows up as a wrong byte.

// File: rtl/eeprom_emu_pkg.sv
package eeprom_emu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_BUSY = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic load;
        logic rd_start;
        logic rd_act;
    } strobe_t;

    // Status byte presented while the internal write runs.
    function automatic logic [7:0] busy_status(input logic last_msb, input logic tog);
        return {~last_msb, tog, 6'b0};
    endfunction

endpackage

// File: rtl/eeprom_pin_sampler.sv
module eeprom_pin_sampler
    import eeprom_emu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ce_n,
    input  logic    we_n,
    input  logic    oe_n,
    output strobe_t stb
);
    logic wr_low, rd_act;
    logic wr_low_q, rd_act_q;

    assign wr_low = ~ce_n & ~we_n;
    assign rd_act = ~ce_n & ~oe_n & we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_low_q <= 1'b0;
            rd_act_q <= 1'b0;
        end else begin
            wr_low_q <= wr_low;
            rd_act_q <= rd_act;
        end
    end

    always_comb begin
        stb.load     = wr_low & ~wr_low_q & oe_n;
        stb.rd_start = rd_act & ~rd_act_q;
        stb.rd_act   = rd_act;
    end

    // R8: a strobe while output enable is low never produces a load
    a_r8_oe_blocks_load: assert property (@(posedge clk) disable iff (rst)
        (!oe_n) |-> !stb.load);

endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
    parameter int OFS_W  = 6,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [7:0]        data_i,
    input  logic              clear_i,
    input  logic [OFS_W-1:0]  rd_idx_i,
    output logic              acc_o,
    output logic              rd_valid_o,
    output logic [7:0]        rd_data_o,
    output logic [PAGE_W-1:0] page_o,
    output logic [7:0]        last_o,
    output logic [(1<<OFS_W)-1:0] mask_o
);
    localparam int PAGE_N = 1 << OFS_W;

    logic [PAGE_N-1:0] mask_q;
    logic [7:0]        pg_data_q [PAGE_N];
    logic [PAGE_W-1:0] page_q;
    logic [7:0]        last_q;

    // R3: the first load of a burst fixes the page; others must match it
    assign acc_o = load_i && ((mask_q == '0) || (page_i == page_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            page_q <= '0;
            last_q <= '0;
        end else if (clear_i) begin
            mask_q <= '0;
        end else if (acc_o) begin
            mask_q[ofs_i] <= 1'b1;
            page_q        <= page_i;
            last_q        <= data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (acc_o && !clear_i) begin
            pg_data_q[ofs_i] <= data_i;
        end
    end

    assign rd_valid_o = mask_q[rd_idx_i];
    assign rd_data_o  = pg_data_q[rd_idx_i];
    assign page_o     = page_q;
    assign last_o     = last_q;
    assign mask_o     = mask_q;

    // R3: once a burst is open its page does not move
    a_r3_page_held: assert property (@(posedge clk) disable iff (rst)
        ((mask_q != '0) && !clear_i) |=> (page_q == $past(page_q)));

    // R2: an accepted load marks its own offset
    a_r2_entry_marked: assert property (@(posedge clk) disable iff (rst)
        (acc_o && !clear_i) |=> mask_q[$past(ofs_i)]);

endmodule

// File: rtl/eeprom_write_seq.sv
module eeprom_write_seq
    import eeprom_emu_pkg::*;
#(
    parameter int OFS_W    = 6,
    parameter int LOAD_TMO = 7500,
    parameter int BUSY_CYC = 250000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_i,
    input  logic             rd_start_i,
    output wr_state_e        state_o,
    output logic             commit_o,
    output logic [OFS_W-1:0] commit_idx_o,
    output logic             clear_o,
    output logic             tog_o
);
    localparam int PAGE_N = 1 << OFS_W;
    localparam int QW     = $clog2(LOAD_TMO + 1);
    localparam int BW     = $clog2(BUSY_CYC + 1);

    wr_state_e state_q;
    logic [QW-1:0] quiet_q;
    logic [BW-1:0] busy_q;
    logic          tog_q;
    logic          quiet_done, busy_done;

    assign quiet_done = (quiet_q == QW'(LOAD_TMO - 1));
    assign busy_done  = (busy_q == BW'(BUSY_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            quiet_q <= '0;
            busy_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (acc_i) begin
                        state_q <= ST_LOAD;
                        quiet_q <= '0;
                    end
                end
                ST_LOAD: begin
                    if (acc_i) begin
                        quiet_q <= '0;
                    end else if (quiet_done) begin
                        state_q <= ST_BUSY;
                        busy_q  <= '0;
                    end else begin
                        quiet_q <= quiet_q + 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (busy_done) begin
                        state_q <= ST_IDLE;
                    end else begin
                        busy_q <= busy_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R6: status bit flips on every read strobe during the busy period
    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q <= 1'b0;
        end else if (state_q == ST_LOAD) begin
            tog_q <= 1'b0;
        end else if ((state_q == ST_BUSY) && rd_start_i) begin
            tog_q <= ~tog_q;
        end
    end

    assign state_o      = state_q;
    assign commit_o     = (state_q == ST_BUSY) && (busy_q < BW'(PAGE_N));
    assign commit_idx_o = busy_q[OFS_W-1:0];
    assign clear_o      = (state_q == ST_BUSY) && busy_done;
    assign tog_o        = tog_q;

    // R4: a quiet window that runs out moves the block into busy
    a_r4_quiet_to_busy: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOAD && !acc_i && quiet_done) |=> (state_q == ST_BUSY));

    // R4: an accepted load keeps the window open
    a_r4_load_extends: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOAD && acc_i) |=> (state_q == ST_LOAD));

    // R5: the busy period is not left before its count completes
    a_r5_no_early_exit: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BUSY && !busy_done) |=> (state_q == ST_BUSY));

    // R6: each busy read strobe inverts the status bit
    a_r6_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BUSY && rd_start_i) |=> (tog_q != $past(tog_q)));

endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/eeprom_emu.sv
module eeprom_emu
    import eeprom_emu_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int OFS_W    = 6,
    parameter int LOAD_TMO = 7500,
    parameter int BUSY_CYC = 250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int PAGE_N = 1 << OFS_W;

    strobe_t           stb;
    wr_state_e         state;
    logic              ld_ok, acc;
    logic              commit, clear, tog;
    logic [OFS_W-1:0]  commit_idx;
    logic              pb_valid;
    logic [7:0]        pb_data, pb_last;
    logic [PAGE_W-1:0] pb_page;
    logic [PAGE_N-1:0] pb_mask;
    logic              arr_we;
    logic [7:0]        arr_rdata;

    eeprom_pin_sampler u_pins (
        .clk  (clk),
        .rst  (rst),
        .ce_n (ce_n),
        .we_n (we_n),
        .oe_n (oe_n),
        .stb  (stb)
    );

    // R5: loads during the busy period never reach the buffer
    assign ld_ok = stb.load && (state != ST_BUSY);

    eeprom_page_buf #(
        .OFS_W  (OFS_W),
        .PAGE_W (PAGE_W)
    ) u_pbuf (
        .clk        (clk),
        .rst        (rst),
        .load_i     (ld_ok),
        .ofs_i      (addr[OFS_W-1:0]),
        .page_i     (addr[ADDR_W-1:OFS_W]),
        .data_i     (din),
        .clear_i    (clear),
        .rd_idx_i   (commit_idx),
        .acc_o      (acc),
        .rd_valid_o (pb_valid),
        .rd_data_o  (pb_data),
        .page_o     (pb_page),
        .last_o     (pb_last),
        .mask_o     (pb_mask)
    );

    eeprom_write_seq #(
        .OFS_W    (OFS_W),
        .LOAD_TMO (LOAD_TMO),
        .BUSY_CYC (BUSY_CYC)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .acc_i        (acc),
        .rd_start_i   (stb.rd_start),
        .state_o      (state),
        .commit_o     (commit),
        .commit_idx_o (commit_idx),
        .clear_o      (clear),
        .tog_o        (tog)
    );

    // R9: only offsets marked in the buffer are written back
    assign arr_we = commit && pb_valid;

    eeprom_array #(
        .ADDR_W (ADDR_W)
    ) u_arr (
        .clk     (clk),
        .we_i    (arr_we),
        .waddr_i ({pb_page, commit_idx}),
        .wdata_i (pb_data),
        .raddr_i (addr),
        .rdata_o (arr_rdata)
    );

    always_comb begin
        if (!stb.rd_act) begin
            dout = '0;
        end else if (state == ST_BUSY) begin
            dout = busy_status(pb_last[7], tog);
        end else begin
            dout = arr_rdata;
        end
    end

    assign dout_en = stb.rd_act;

    // R10: an undriven bus always carries zero
    a_r10_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        (!dout_en) |-> (dout == '0));

    // R7: busy reads complement the most significant bit of the last byte
    a_r7_poll_msb: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY && dout_en) |-> (dout[7] != pb_last[7] && dout[5:0] == '0));

    // R8: with output enable low and no busy period, the load mask stays put
    a_r8_mask_kept: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && state != ST_BUSY) |=> (pb_mask == $past(pb_mask)));

    // R5: the array is written only inside a busy period
    a_r5_write_in_busy: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (state == ST_BUSY));

endmodule

// File: tb/eeprom_emu_tb.sv
module eeprom_emu_tb;
    localparam int AW  = 11;
    localparam int TMO = 40;
    localparam int BSY = 120;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en;

    eeprom_emu #(
        .ADDR_W   (AW),
        .OFS_W    (6),
        .LOAD_TMO (TMO),
        .BUSY_CYC (BSY)
    ) u_dut (
        .clk     (clk),
        .rst     (rst),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [7:0] val;
        logic       en;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    logic smp = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    logic done = 1'b0;

    // Monitor: pops one expected item per sample request, away from the clock edge
    always @(negedge clk) begin
        if (smp && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (dout_en !== e.en || dout !== e.val) begin
                n_fail++;
                $display("FAIL %s: got en=%0b data=%02h, expected en=%0b data=%02h",
                         e.req, dout_en, dout, e.en, e.val);
            end
        end
    end

    function automatic logic [7:0] fill(input int i);
        return 8'(i * 7 + 3);
    endfunction

    function automatic logic [AW-1:0] at(input int page, input int ofs);
        return AW'(page * 64 + ofs);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_now(input logic [7:0] v, input logic en, input string req);
        exp_t e;
        e.val = v; e.en = en; e.req = req;
        exp_q.push_back(e);
        smp = 1'b1;
        tick(1);
        smp = 1'b0;
    endtask

    task automatic load_byte(input logic [AW-1:0] a, input logic [7:0] d, input logic oe_lvl);
        tick(1);
        addr = a; din = d; oe_n = oe_lvl; ce_n = 1'b0; we_n = 1'b0;
        tick(2);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        tick(1);
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input logic [7:0] v, input string req);
        tick(1);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        tick(2);
        expect_now(v, 1'b1, req);
        ce_n = 1'b1; oe_n = 1'b1;
        tick(1);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        // R11: idle after reset, bus not driven
        expect_now(8'h00, 1'b0, "R11 reset idle");

        // Fill page 3 completely; last byte fill(63)=0xBC has bit7=1
        for (int i = 0; i < 64; i++) load_byte(at(3, i), fill(i), 1'b0 ^ 1'b1);
        tick(TMO + 5);
        // R6/R7: status 0x40 then 0x00 (D7=~1, D6 alternates starting at 1)
        read_chk(at(3, 0), 8'h40, "R6 R7 first busy read");
        read_chk(at(3, 0), 8'h00, "R6 R7 second busy read");
        // R5: a load during busy is ignored
        load_byte(at(3, 20), 8'hEE, 1'b1);
        read_chk(at(3, 1), 8'h40, "R6 third busy read");
        tick(BSY + 10);
        read_chk(at(3, 0),  fill(0),  "R1 offset 0");
        read_chk(at(3, 63), fill(63), "R1 offset 63");
        read_chk(at(3, 20), fill(20), "R5 busy load ignored");

        // Partial burst with a foreign page and an output-enable-low strobe
        load_byte(at(3, 5), 8'h11, 1'b1);
        load_byte(at(3, 6), 8'h22, 1'b1);
        load_byte(at(4, 8), 8'h33, 1'b1);
        load_byte(at(3, 9), 8'h44, 1'b0);
        load_byte(at(3, 7), 8'h55, 1'b1);
        tick(TMO + BSY + 20);
        read_chk(at(3, 5),  8'h11,    "R2 offset 5");
        read_chk(at(3, 6),  8'h22,    "R2 offset 6");
        read_chk(at(3, 7),  8'h55,    "R2 offset 7");
        read_chk(at(3, 4),  fill(4),  "R9 offset 4 kept");
        read_chk(at(3, 10), fill(10), "R9 offset 10 kept");
        read_chk(at(3, 8),  fill(8),  "R3 foreign page dropped");
        read_chk(at(3, 9),  fill(9),  "R8 oe-low strobe ignored");

        // R4: before expiry a read returns true (old) data
        load_byte(at(3, 40), 8'h99, 1'b1);
        tick(20);
        read_chk(at(3, 40), fill(40), "R4 no status before expiry");
        tick(TMO + BSY + 20);
        read_chk(at(3, 40), 8'h99, "R2 offset 40");

        // R4: load exactly on the expiring cycle (gap 40) joins the burst
        load_byte(at(3, 30), 8'hA1, 1'b1);
        tick(TMO - 4);
        load_byte(at(3, 31), 8'hA2, 1'b1);
        tick(TMO + BSY + 20);
        read_chk(at(3, 30), 8'hA1, "R4 gap-40 first byte");
        read_chk(at(3, 31), 8'hA2, "R4 gap-40 second byte");

        // R4: one cycle later (gap 41) the second load falls into busy
        load_byte(at(3, 32), 8'hA3, 1'b1);
        tick(TMO - 3);
        load_byte(at(3, 33), 8'hA4, 1'b1);
        tick(TMO + BSY + 20);
        read_chk(at(3, 32), 8'hA3,    "R4 gap-41 first byte");
        read_chk(at(3, 33), fill(33), "R4 gap-41 second byte dropped");

        // R10: bus flag only for ce low, oe low, we high
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        tick(2);
        expect_now(8'h00, 1'b0, "R10 we low");
        ce_n = 1'b1; we_n = 1'b1;
        tick(2);
        expect_now(8'h00, 1'b0, "R10 ce high");
        ce_n = 1'b0; oe_n = 1'b1;
        tick(2);
        expect_now(8'h00, 1'b0, "R10 oe high");
        ce_n = 1'b1;
        tick(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule